// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a processor subsystem. A free-running up-counter advances on a tick taken from a power-of-two prescaler of the system clock. If software does not restart it before it wraps, the block drives a reset pulse of fixed length to the rest of the system. The counter is 16 bits wide by default.

Software sees a single 8-bit control register. It holds a run enable, a restart strobe and a 3-bit rate code. Writing the restart strobe as 1 zeroes the counter and the prescaler, so the full timeout begins again. Both the external reset and the watchdog's own reset pulse turn the enable off. A disabled watchdog keeps its counter and prescaler at zero.

Top module: `wdt_prescaled`

## Requirements
- R1: While rst_ni is low, and right after it is released, rd_data_o reads 0x00 and wdt_rst_o is low. A low rst_ni during a running count cancels that count, so no watchdog reset follows.
- R2: Register layout: bit 7 is the enable, bits 2:0 are the rate code, and bit 5 is the restart strobe. Reads return the enable in bit 7 and the code in bits 2:0. Bits 6, 5, 4 and 3 always read 0.
- R3: With the enable set and rate code n (0..7), the counter advances once every 2^(n+1) clocks. wdt_rst_o first goes high right after the clock edge that comes 2^CNT_W * 2^(n+1) edges after the edge that accepted the enabling write.
- R4: Each watchdog reset holds wdt_rst_o high for exactly PULSE_LEN (4) clock cycles.
- R5: A watchdog reset clears the enable bit and keeps the rate code. No further reset follows until software enables the watchdog again.
- R6: A write with bit 5 set zeroes the counter and the prescaler. The next timeout is then measured from that write edge.
- R7: A write that repeats the running configuration with bit 5 clear leaves the timeout where it was.
- R8: While the enable is clear, no reset is produced and the counter and prescaler are held at zero. Enabling again starts a full timeout.
- R9: Register writes that arrive while wdt_rst_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse to the system |

## Verification
The hardest case to reach from the ports is the slowest prescaler code at the full 16-bit width, because that timeout is far beyond any bench run. The bench therefore runs a second instance with a 4-bit counter and sweeps all eight rate codes through complete timeouts to the exact cycle. The default-width instance is then taken through one full timeout at the fastest code. Restart, a repeated write without restart, disable and a write that lands during the pulse are all placed mid-count, and each is judged by when the next pulse rises, or by the absence of a pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned RST_BIT = 5;
  localparam int unsigned SEL_W   = 3;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              ovf_i,
  input  logic              busy_i,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              restart_o,
  output logic [CTRL_W-1:0] rd_data_o
);
  localparam logic [CTRL_W-1:0] USED_MASK =
    CTRL_W'((1 << EN_BIT) | (1 << RST_BIT) | ((1 << SEL_W) - 1));

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_ok;
  logic             unused_bits;

  assign wr_ok       = wr_en_i & ~busy_i;
  assign restart_o   = wr_ok & wr_data_i[RST_BIT];
  assign unused_bits = ^(wr_data_i & ~USED_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (ovf_i) begin
      en_q  <= 1'b0;  // watchdog reset drops enable, code kept
    end else if (wr_ok) begin
      en_q  <= wr_data_i[EN_BIT];
      sel_q <= wr_data_i[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[EN_BIT]        = en_q;
    rd_data_o[SEL_W-1:0]     = sel_q;
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

  AST_EN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> !en_q); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(en_q) && $stable(sel_q))); // R9
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NCODE = 1 << SEL_W;
  localparam int unsigned PRE_W = NCODE;

  logic [PRE_W-1:0] pre_q;
  logic [NCODE-1:0] hit;

  // code g fires when the low g+1 bits are all ones: period 2^(g+1)
  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    assign hit[g] = &pre_q[g:0];
  end

  assign tick_o = run_i & hit[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pre_q <= '0;
    else if (!run_i || clr_i)  pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end

  AST_PRE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0)); // R8
  AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0)); // R6
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  // restart in the same cycle wins over overflow
  assign ovf_o = tick_i & (&cnt_q) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || clr_i) cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0)); // R3
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R8
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !clr_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic act_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (trig_i && cnt_q == '0)   cnt_q <= PW'(PULSE_LEN);
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !act_o) |=> act_o); // R4
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && cnt_q != PW'(1)) |=> act_o); // R4
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == PW'(1) && !trig_i) |=> !act_o); // R4
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              wdt_rst_o
);
  logic             en;
  logic [SEL_W-1:0] sel;
  logic             restart;
  logic             tick;
  logic             ovf;
  logic             busy;

  wdt_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ovf_i     (ovf),
    .busy_i    (busy),
    .en_o      (en),
    .sel_o     (sel),
    .restart_o (restart),
    .rd_data_o (rd_data_o)
  );

  wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en),
    .clr_i  (restart),
    .sel_i  (sel),
    .tick_o (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en),
    .clr_i  (restart),
    .tick_i (tick),
    .ovf_o  (ovf)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (ovf),
    .act_o  (busy)
  );

  assign wdt_rst_o = busy;

  AST_NO_RUN_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> !rd_data_o[EN_BIT]); // R5
endmodule

// File: tb/wdt_prescaled_test.sv
`timescale 1ns/1ps
module wdt_prescaled_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_b = 1'b0, wr_s = 1'b0;
  logic [7:0] wd_b = '0, wd_s = '0;
  logic [7:0] rd_b, rd_s;
  logic       wrst_b, wrst_s;
  int         cyc = 0;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;
  int         q_b[$], q_s[$];

  localparam int SMALL_W = 4;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_prescaled uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_b), .wr_data_i(wd_b),
    .rd_data_o(rd_b), .wdt_rst_o(wrst_b));

  wdt_prescaled #(.CNT_W(SMALL_W)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_s), .wr_data_i(wd_s),
    .rd_data_o(rd_s), .wdt_rst_o(wrst_s));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive a write; c returns the cycle index of the accepting edge
  task automatic wr(input bit big, input logic [7:0] d, output int c);
    @(negedge clk);
    if (big) begin wr_b = 1'b1; wd_b = d; end
    else     begin wr_s = 1'b1; wd_s = d; end
    c = cyc + 1;
    @(negedge clk);
    wr_b = 1'b0; wr_s = 1'b0;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  function automatic int small_to(input int n);
    return (1 << SMALL_W) * (2 << n);
  endfunction

  // monitors: pop expected rise cycle, then check pulse width
  logic prev_b = 1'b0, prev_s = 1'b0;
  int   fall_b = -1, fall_s = -1;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s <= 1'b0;
    end else begin
      if (wrst_s && !prev_s) begin
        if (q_s.size() == 0) chk(1'b0, "R3/R5/R8 unexpected reset (small)", cyc, -1);
        else begin
          int e;
          e = q_s.pop_front();
          chk(cyc == e, "R3 reset rise (small)", cyc, e);
        end
        fall_s <= cyc + 4;
      end
      if (!wrst_s && prev_s) chk(cyc == fall_s, "R4 pulse width (small)", cyc, fall_s);
      prev_s <= wrst_s;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_b <= 1'b0;
    end else begin
      if (wrst_b && !prev_b) begin
        if (q_b.size() == 0) chk(1'b0, "R3 unexpected reset (big)", cyc, -1);
        else begin
          int e;
          e = q_b.pop_front();
          chk(cyc == e, "R3 reset rise (big)", cyc, e);
        end
        fall_b <= cyc + 4;
      end
      if (!wrst_b && prev_b) chk(cyc == fall_b, "R4 pulse width (big)", cyc, fall_b);
      prev_b <= wrst_b;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog timeout", cyc, 195000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c, c2, e;
    repeat (3) @(negedge clk);
    chk(rd_s == 8'h00 && rd_b == 8'h00, "R1 reset read", rd_s, 0);
    chk(!wrst_s && !wrst_b, "R1 reset output", wrst_s, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_s == 8'h00 && !wrst_s, "R1 after release", rd_s, 0);

    // R2 read-back: reserved bits and restart bit read 0
    wr(0, 8'h7D, c);
    chk(rd_s == 8'h05, "R2 readback disabled", rd_s, 8'h05);
    wr(0, 8'hFA, c);
    q_s.push_back(c + small_to(2));
    chk(rd_s == 8'h82, "R2 readback enabled", rd_s, 8'h82);
    wait_cyc(c + small_to(2) + 6);
    chk(rd_s == 8'h02, "R5 enable cleared, code kept", rd_s, 8'h02);
    wait_cyc(cyc + 300);  // R5: monitor flags any second pulse

    // R3 sweep all codes
    for (int n = 0; n < 8; n++) begin
      wr(0, 8'h80 | 8'(n), c);
      q_s.push_back(c + small_to(n));
      wait_cyc(c + small_to(n) + 6);
      chk(rd_s == 8'(n), "R3/R5 code retained after timeout", rd_s, n);
    end

    // R6 restart mid count
    wr(0, 8'h83, c);
    wait_cyc(c + 100);
    wr(0, 8'hA3, c2);
    q_s.push_back(c2 + small_to(3));
    wait_cyc(c2 + small_to(3) + 6);
    chk(q_s.size() == 0, "R6 restart timeout consumed", q_s.size(), 0);

    // R7 repeat write without restart
    wr(0, 8'h81, c);
    q_s.push_back(c + small_to(1));
    wait_cyc(c + 20);
    wr(0, 8'h81, c2);
    wait_cyc(c + small_to(1) + 6);
    chk(q_s.size() == 0, "R7 timeout unchanged", q_s.size(), 0);

    // R8 disable holds, re-enable starts full timeout
    wr(0, 8'h80, c);
    wait_cyc(c + 20);
    wr(0, 8'h00, c2);
    wait_cyc(cyc + 100);
    chk(!wrst_s && rd_s == 8'h00, "R8 disabled no reset", rd_s, 0);
    wr(0, 8'h80, c);
    q_s.push_back(c + small_to(0));
    wait_cyc(c + small_to(0) + 6);
    chk(q_s.size() == 0, "R8 full timeout after re-enable", q_s.size(), 0);

    // R9 write during pulse is ignored
    wr(0, 8'h80, c);
    e = c + small_to(0);
    q_s.push_back(e);
    wait_cyc(e);
    chk(wrst_s, "R9 pulse active before write", wrst_s, 1);
    wr(0, 8'h87, c2);
    wait_cyc(e + 6);
    chk(rd_s == 8'h00 && !wrst_s, "R9 write ignored", rd_s, 0);
    wait_cyc(cyc + 200);

    // R1 hardware reset cancels a running count
    wr(0, 8'h80, c);
    wait_cyc(c + 10);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(rd_s == 8'h00 && !wrst_s, "R1 reset mid count", rd_s, 0);
    rst_n = 1'b1;
    wait_cyc(cyc + 100);
    chk(!wrst_s && rd_s == 8'h00, "R1 no reset after cancel", rd_s, 0);

    // R3 default 16-bit width, code 0
    wr(1, 8'h80, c);
    q_b.push_back(c + 65536 * 2);
    chk(rd_b == 8'h80, "R2 readback big", rd_b, 8'h80);
    wait_cyc(c + 65536 * 2 + 6);
    chk(q_b.size() == 0 && rd_b == 8'h00, "R3/R5 big timeout", rd_b, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule